// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the transfer pointers of a multi-channel DMA engine. Every channel owns four 16-bit values: a starting address and a starting count that software programs, and a working address and a working count that move as transfers complete. Software reaches them through an 8-bit register port. A single low/high byte pointer is shared by all channels and flips after each register access, so a 16-bit value goes in or comes out as two consecutive byte accesses.

The transfer side gives the block a one-cycle strobe and a channel index. The block presents that channel's working address on `xfer_addr`. On the clock edge it moves the address one step up or down, as the channel's mode asks, and lowers the count by one. When the count is already zero, or when the end-of-process input comes with the strobe, the block raises `tc_out` in that cycle. A channel with automatic reload enabled then copies its starting values back into the working registers. Arbitration, bus-cycle timing and pin drivers belong to neighbouring blocks.

Top module: `dma_ptr_regs`

## Requirements
- R1: After reset every address and count register reads 0x0000, the byte pointer points at the low byte, every channel counts upward with reload disabled, `xfer_addr` is 0 and `tc_out` is low.
- R2: A CPU write (`cpu_sel` and `cpu_wr`) at offset `{0, ch[1:0], k}` writes one byte into both the starting and the working copy of channel `ch`, where k=0 selects the address and k=1 the count. The byte pointer picks which byte is written.
- R3: Every read or write at offsets 0x0 to 0x7 flips the shared byte pointer. A write to offset 0xC returns the pointer to the low byte, whatever the data.
- R4: A read at offset `{0, ch, k}` returns the byte of the working address or working count that the pointer selects, in the same cycle on `cpu_rdata`. Reads that are not register reads return 0.
- R5: During a transfer strobe, `xfer_addr` shows the working address of `xfer_ch`. After the edge that address has grown by one (decrement bit 0) or shrunk by one (decrement bit 1), and the working count is one lower.
- R6: `tc_out` goes high with a strobe whose channel count is 0x0000, so a programmed count N yields N+1 transfers. Without reload the count wraps to 0xFFFF and the address still steps.
- R7: With reload enabled, a terminal count copies the starting address and count into the working registers in place of the step. The starting copies never change because of transfers.
- R8: `eop_in` high together with a strobe ends the channel's run exactly like a terminal count, reload included, whatever the count.
- R9: A write to offset 0xB sets the mode of the channel named by data[1:0]: data[4] enables reload and data[5] selects decrement.
- R10: A write to offset 0xD returns the byte pointer to low and clears every channel's mode. Address and count values are kept.
- R11: When a CPU register write and a strobe target the same channel in the same cycle, the write takes effect, the strobe is ignored and `tc_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | Register port selected |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, same cycle |
| xfer_stb | input | 1 | One transfer finished on `xfer_ch` |
| xfer_ch | input | 2 | Channel of the transfer |
| eop_in | input | 1 | External end of process, qualified by `xfer_stb` |
| xfer_addr | output | 16 | Working address of `xfer_ch` |
| tc_out | output | 1 | Terminal count for the strobed channel |

## Verification
The assertions take it that `cpu_wr` and `cpu_rd` are never high together, and that every strobe is a single cycle sampled at one edge. The stimulus drives inputs only at falling edges, issues exactly one CPU access or one transfer per cycle, and raises both CPU strobes together in none of them. The single exception is the deliberate collision test, which pairs a register write with a strobe on the same channel. Because the byte pointer is shared state, every sequence is planned with the pointer's position known. Each test either starts with the clear command or follows an even number of register accesses.

// File: rtl/dma_ptr_pkg.sv
// Package: shared widths, command offsets and mode bit positions for the
// DMA pointer register file. Assumes an 8-bit register port and 16-bit registers.
package dma_ptr_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 2 * BYTE_W;
    localparam int ADDR_W = 4;

    // Command offsets (decoded when cpu_addr[3] is set)
    localparam logic [ADDR_W-1:0] OFF_MODE   = 4'hB;
    localparam logic [ADDR_W-1:0] OFF_CLRPTR = 4'hC;
    localparam logic [ADDR_W-1:0] OFF_MCLR   = 4'hD;

    // Bit positions inside the mode byte
    localparam int MODE_AUTO_BIT = 4;
    localparam int MODE_DEC_BIT  = 5;

    typedef struct packed {
        logic auto_init;
        logic dec;
    } ch_mode_t;
endpackage

// File: rtl/dma_ptr_decode.sv
// Module: dma_ptr_decode
// Decodes the 8-bit register port into per-channel register writes, mode
// writes and commands, and keeps the shared low/high byte pointer.
// Assumes cpu_wr and cpu_rd are one-cycle strobes and never high together,
// and NUM_CH is 2 or 4 so that the channel index fits in cpu_addr[2:1].
module dma_ptr_decode
    import dma_ptr_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_sel,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [BYTE_W-1:0]  cpu_wdata,
    output logic [NUM_CH-1:0]  reg_wr,
    output logic               reg_is_cnt,
    output logic               ptr_hi,
    output logic [NUM_CH-1:0]  mode_wr,
    output logic               mode_auto,
    output logic               mode_dec,
    output logic               mclr
);
    logic is_reg;
    logic reg_access;
    logic clr_ptr;

    // Classify the current access
    always_comb begin
        is_reg     = cpu_sel && !cpu_addr[ADDR_W-1];
        reg_access = is_reg && (cpu_wr || cpu_rd);
        clr_ptr    = cpu_sel && cpu_wr && (cpu_addr == OFF_CLRPTR);
        mclr       = cpu_sel && cpu_wr && (cpu_addr == OFF_MCLR);
        reg_is_cnt = cpu_addr[0];
        mode_auto  = cpu_wdata[MODE_AUTO_BIT];
        mode_dec   = cpu_wdata[MODE_DEC_BIT];
    end

    // Per-channel write enables for registers and modes
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            reg_wr[i]  = is_reg && cpu_wr && (cpu_addr[CH_W:1] == CH_W'(i));
            mode_wr[i] = cpu_sel && cpu_wr && (cpu_addr == OFF_MODE)
                         && (cpu_wdata[CH_W-1:0] == CH_W'(i));
        end
    end

    // Shared byte pointer: cleared by commands, flipped by register accesses
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_hi <= 1'b0;
        else if (clr_ptr || mclr)
            ptr_hi <= 1'b0;
        else if (reg_access)
            ptr_hi <= !ptr_hi;
    end
endmodule

// File: rtl/dma_ptr_channel.sv
// Module: dma_ptr_channel
// One channel: starting and working address/count pairs, mode bits, the step
// on a transfer and the terminal-count reload. A CPU write to this channel
// wins over a transfer in the same cycle.
module dma_ptr_channel
    import dma_ptr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_is_cnt,
    input  logic               wr_hi,
    input  logic [BYTE_W-1:0]  wr_byte,
    input  logic               mode_wr,
    input  logic               mode_auto,
    input  logic               mode_dec,
    input  logic               mclr,
    input  logic               step,
    input  logic               term,
    output logic [REG_W-1:0]   cur_addr,
    output logic [REG_W-1:0]   cur_cnt,
    output logic [REG_W-1:0]   base_addr,
    output logic [REG_W-1:0]   base_cnt,
    output logic               auto_en,
    output logic               tc
);
    ch_mode_t   mode_q;
    logic       step_eff;
    logic [REG_W-1:0] addr_next;

    // Qualify the transfer and detect the end of the run
    always_comb begin
        step_eff  = step && !reg_wr;
        tc        = step_eff && ((cur_cnt == '0) || term);
        addr_next = mode_q.dec ? cur_addr - REG_W'(1) : cur_addr + REG_W'(1);
        auto_en   = mode_q.auto_init;
    end

    // Mode bits: cleared by master clear, loaded by a mode write
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)
            mode_q <= '0;
        else if (mode_wr)
            mode_q <= '{auto_init: mode_auto, dec: mode_dec};
    end

    // Starting copies change only through CPU byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else if (reg_wr) begin
            if (reg_is_cnt) begin
                if (wr_hi) base_cnt[REG_W-1:BYTE_W] <= wr_byte;
                else       base_cnt[BYTE_W-1:0]     <= wr_byte;
            end else begin
                if (wr_hi) base_addr[REG_W-1:BYTE_W] <= wr_byte;
                else       base_addr[BYTE_W-1:0]     <= wr_byte;
            end
        end
    end

    // Working copies: CPU byte write, reload on terminal count, or step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (reg_wr) begin
            if (reg_is_cnt) begin
                if (wr_hi) cur_cnt[REG_W-1:BYTE_W] <= wr_byte;
                else       cur_cnt[BYTE_W-1:0]     <= wr_byte;
            end else begin
                if (wr_hi) cur_addr[REG_W-1:BYTE_W] <= wr_byte;
                else       cur_addr[BYTE_W-1:0]     <= wr_byte;
            end
        end else if (tc && mode_q.auto_init) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
        end else if (step_eff) begin
            cur_addr <= addr_next;
            cur_cnt  <= cur_cnt - REG_W'(1);
        end
    end
endmodule

// File: rtl/dma_ptr_regs.sv
// Module: dma_ptr_regs (top)
// Per-channel DMA address/count register file with an 8-bit byte-sequenced
// register port, transfer stepping, terminal count and automatic reload.
// Assumes NUM_CH is 2 or 4 and inputs are synchronous to clk.
module dma_ptr_regs
    import dma_ptr_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_sel,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [BYTE_W-1:0]  cpu_wdata,
    output logic [BYTE_W-1:0]  cpu_rdata,
    input  logic               xfer_stb,
    input  logic [CH_W-1:0]    xfer_ch,
    input  logic               eop_in,
    output logic [REG_W-1:0]   xfer_addr,
    output logic               tc_out
);
    logic [NUM_CH-1:0]             reg_wr;
    logic [NUM_CH-1:0]             mode_wr;
    logic                          reg_is_cnt;
    logic                          ptr_hi;
    logic                          mode_auto;
    logic                          mode_dec;
    logic                          mclr;
    logic [NUM_CH-1:0]             tc_vec;
    logic [NUM_CH-1:0]             auto_en;
    logic [NUM_CH-1:0][REG_W-1:0]  cur_addr;
    logic [NUM_CH-1:0][REG_W-1:0]  cur_cnt;
    logic [NUM_CH-1:0][REG_W-1:0]  base_addr;
    logic [NUM_CH-1:0][REG_W-1:0]  base_cnt;
    logic [REG_W-1:0]              rd_word;
    logic [CH_W-1:0]               rd_ch;

    dma_ptr_decode #(.NUM_CH(NUM_CH)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_sel    (cpu_sel),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .reg_wr     (reg_wr),
        .reg_is_cnt (reg_is_cnt),
        .ptr_hi     (ptr_hi),
        .mode_wr    (mode_wr),
        .mode_auto  (mode_auto),
        .mode_dec   (mode_dec),
        .mclr       (mclr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_ptr_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .reg_wr     (reg_wr[g]),
            .reg_is_cnt (reg_is_cnt),
            .wr_hi      (ptr_hi),
            .wr_byte    (cpu_wdata),
            .mode_wr    (mode_wr[g]),
            .mode_auto  (mode_auto),
            .mode_dec   (mode_dec),
            .mclr       (mclr),
            .step       (xfer_stb && (xfer_ch == CH_W'(g))),
            .term       (eop_in),
            .cur_addr   (cur_addr[g]),
            .cur_cnt    (cur_cnt[g]),
            .base_addr  (base_addr[g]),
            .base_cnt   (base_cnt[g]),
            .auto_en    (auto_en[g]),
            .tc         (tc_vec[g])
        );
    end

    // Read path: pick channel word, then the byte the pointer selects
    always_comb begin
        rd_ch     = cpu_addr[CH_W:1];
        rd_word   = reg_is_cnt ? cur_cnt[rd_ch] : cur_addr[rd_ch];
        cpu_rdata = '0;
        if (cpu_sel && cpu_rd && !cpu_addr[ADDR_W-1])
            cpu_rdata = ptr_hi ? rd_word[REG_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
    end

    // Transfer-side outputs
    always_comb begin
        xfer_addr = cur_addr[xfer_ch];
        tc_out    = |tc_vec;
    end
endmodule

// File: rtl/dma_ptr_regs_chk.sv
// Module: dma_ptr_regs_chk
// Property checker bound to dma_ptr_regs. Assumes cpu_wr and cpu_rd are
// never high together.
module dma_ptr_regs_chk #(
    parameter int NUM_CH = 4,
    parameter int AW     = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cpu_sel,
    input logic                         cpu_wr,
    input logic                         cpu_rd,
    input logic [3:0]                   cpu_addr,
    input logic                         xfer_stb,
    input logic [CH_W-1:0]              xfer_ch,
    input logic                         tc_out,
    input logic                         ptr_hi,
    input logic [NUM_CH-1:0]            auto_en,
    input logic [NUM_CH-1:0][AW-1:0]    cur_addr,
    input logic [NUM_CH-1:0][AW-1:0]    cur_cnt,
    input logic [NUM_CH-1:0][AW-1:0]    base_addr,
    input logic [NUM_CH-1:0][AW-1:0]    base_cnt
);
    logic collide;
    logic any_wr;

    // Same-channel CPU write during a strobe
    always_comb begin
        collide = cpu_sel && cpu_wr && !cpu_addr[3] && (cpu_addr[CH_W:1] == xfer_ch);
        any_wr  = cpu_sel && cpu_wr;
    end

    a_r3_ptr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && (cpu_wr || cpu_rd) && !cpu_addr[3]) |=> (ptr_hi != $past(ptr_hi)));

    a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && cpu_addr == 4'hC) |=> !ptr_hi);

    a_r10_mclr_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && cpu_addr == 4'hD) |=> (!ptr_hi && auto_en == '0));

    a_r6_tc_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !collide && cur_cnt[xfer_ch] == '0) |-> tc_out);

    a_r11_no_tc_on_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && collide) |-> !tc_out);

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !collide && !(tc_out && auto_en[xfer_ch]))
        |=> (cur_cnt[$past(xfer_ch)] == $past(cur_cnt[xfer_ch]) - AW'(1)));

    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_out && auto_en[xfer_ch])
        |=> (cur_addr[$past(xfer_ch)] == $past(base_addr[xfer_ch])
             && cur_cnt[$past(xfer_ch)] == $past(base_cnt[xfer_ch])));

    a_r7_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> ($stable(base_addr) && $stable(base_cnt)));

    a_r2_wr_rd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_rd));
endmodule

bind dma_ptr_regs dma_ptr_regs_chk #(.NUM_CH(NUM_CH), .AW(dma_ptr_pkg::REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sel   (cpu_sel),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_addr  (cpu_addr),
    .xfer_stb  (xfer_stb),
    .xfer_ch   (xfer_ch),
    .tc_out    (tc_out),
    .ptr_hi    (ptr_hi),
    .auto_en   (auto_en),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt),
    .base_addr (base_addr),
    .base_cnt  (base_cnt)
);

// File: tb/dma_ptr_regs_bench.sv
// Bench for dma_ptr_regs: a vector table walked by one loop, then directed
// tests for reset, pointer handling and write/transfer collision.
module dma_ptr_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_sel, cpu_wr, cpu_rd;
    logic [3:0]  cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [7:0]  cpu_rdata;
    logic        xfer_stb;
    logic [1:0]  xfer_ch;
    logic        eop_in;
    logic [15:0] xfer_addr;
    logic        tc_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = !clk;

    dma_ptr_regs u_dma_ptr_regs (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .xfer_stb(xfer_stb), .xfer_ch(xfer_ch),
        .eop_in(eop_in), .xfer_addr(xfer_addr), .tc_out(tc_out)
    );

    // op: 0 write, 1 read and check byte, 2 transfer (data[1:0] ch, data[2] eop)
    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [7:0]  data;
        logic        tc;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'hC, 8'h00, 1'b0, 16'h0000, 4'd3},  // R3 clear pointer
        '{2'd0, 4'h0, 8'h34, 1'b0, 16'h0000, 4'd2},  // R2 ch0 address
        '{2'd0, 4'h0, 8'h12, 1'b0, 16'h0000, 4'd2},
        '{2'd0, 4'h1, 8'h02, 1'b0, 16'h0000, 4'd2},  // R2 ch0 count
        '{2'd0, 4'h1, 8'h00, 1'b0, 16'h0000, 4'd2},
        '{2'd1, 4'h0, 8'h00, 1'b0, 16'h0034, 4'd4},  // R4 readback
        '{2'd1, 4'h0, 8'h00, 1'b0, 16'h0012, 4'd4},
        '{2'd1, 4'h1, 8'h00, 1'b0, 16'h0002, 4'd4},
        '{2'd1, 4'h1, 8'h00, 1'b0, 16'h0000, 4'd4},
        '{2'd2, 4'h0, 8'h00, 1'b0, 16'h1234, 4'd5},  // R5 increment
        '{2'd2, 4'h0, 8'h00, 1'b0, 16'h1235, 4'd5},
        '{2'd2, 4'h0, 8'h00, 1'b1, 16'h1236, 4'd6},  // R6 third transfer ends run
        '{2'd1, 4'h1, 8'h00, 1'b0, 16'h00FF, 4'd6},  // R6 count wrapped
        '{2'd1, 4'h1, 8'h00, 1'b0, 16'h00FF, 4'd6},
        '{2'd1, 4'h0, 8'h00, 1'b0, 16'h0037, 4'd6},  // R6 address stepped
        '{2'd1, 4'h0, 8'h00, 1'b0, 16'h0012, 4'd6},
        '{2'd0, 4'hB, 8'h31, 1'b0, 16'h0000, 4'd9},  // R9 ch1 reload + decrement
        '{2'd0, 4'h2, 8'h00, 1'b0, 16'h0000, 4'd2},
        '{2'd0, 4'h2, 8'h80, 1'b0, 16'h0000, 4'd2},
        '{2'd0, 4'h3, 8'h01, 1'b0, 16'h0000, 4'd2},
        '{2'd0, 4'h3, 8'h00, 1'b0, 16'h0000, 4'd2},
        '{2'd2, 4'h0, 8'h01, 1'b0, 16'h8000, 4'd5},  // R5 decrement
        '{2'd2, 4'h0, 8'h01, 1'b1, 16'h7FFF, 4'd7},  // R7 terminal count
        '{2'd2, 4'h0, 8'h01, 1'b0, 16'h8000, 4'd7},  // R7 reloaded
        '{2'd2, 4'h0, 8'h05, 1'b1, 16'h7FFF, 4'd8},  // R8 external end
        '{2'd1, 4'h2, 8'h00, 1'b0, 16'h0000, 4'd8},  // R8 reload after end
        '{2'd1, 4'h2, 8'h00, 1'b0, 16'h0080, 4'd8},
        '{2'd1, 4'h3, 8'h00, 1'b0, 16'h0001, 4'd8},
        '{2'd1, 4'h3, 8'h00, 1'b0, 16'h0000, 4'd8},
        '{2'd0, 4'h4, 8'hAA, 1'b0, 16'h0000, 4'd3},  // R3 leave pointer high
        '{2'd0, 4'hC, 8'h5A, 1'b0, 16'h0000, 4'd3},
        '{2'd0, 4'h4, 8'h55, 1'b0, 16'h0000, 4'd3},
        '{2'd0, 4'h4, 8'h66, 1'b0, 16'h0000, 4'd3},
        '{2'd1, 4'h4, 8'h00, 1'b0, 16'h0055, 4'd3},
        '{2'd1, 4'h4, 8'h00, 1'b0, 16'h0066, 4'd3},
        '{2'd0, 4'h6, 8'h11, 1'b0, 16'h0000, 4'd10}, // R10 leave pointer high
        '{2'd0, 4'hD, 8'h00, 1'b0, 16'h0000, 4'd10},
        '{2'd0, 4'h6, 8'h22, 1'b0, 16'h0000, 4'd10},
        '{2'd0, 4'h6, 8'h33, 1'b0, 16'h0000, 4'd10},
        '{2'd1, 4'h6, 8'h00, 1'b0, 16'h0022, 4'd10},
        '{2'd1, 4'h6, 8'h00, 1'b0, 16'h0033, 4'd10},
        '{2'd2, 4'h0, 8'h01, 1'b0, 16'h8000, 4'd10}, // R10 mode cleared: up
        '{2'd2, 4'h0, 8'h01, 1'b1, 16'h8001, 4'd10}, // R10 no reload
        '{2'd2, 4'h0, 8'h01, 1'b0, 16'h8002, 4'd10},
        '{2'd2, 4'h0, 8'h04, 1'b1, 16'h1237, 4'd8},  // R8 end without reload
        '{2'd2, 4'h0, 8'h00, 1'b0, 16'h1238, 4'd8}
    };

    task automatic check(input bit ok, input int req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge
    task automatic drive(input bit sel, input bit wr, input bit rd,
                         input logic [3:0] a, input logic [7:0] d,
                         input bit stb, input logic [1:0] ch, input bit eop);
        @(negedge clk);
        cpu_sel = sel; cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
        xfer_stb = stb; xfer_ch = ch; eop_in = eop;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input int req);
        drive(1, 0, 1, a, 8'h00, 0, 2'd0, 0);
        #4;
        check(cpu_rdata == exp, req, {8'h00, cpu_rdata}, {8'h00, exp});
    endtask

    task automatic xfer_chk(input logic [1:0] ch, input bit eop,
                            input logic [15:0] exp, input bit exp_tc, input int req);
        drive(0, 0, 0, 4'h0, 8'h00, 1, ch, eop);
        #4;
        check(xfer_addr == exp, req, xfer_addr, exp);
        check(tc_out == exp_tc, req, {15'd0, tc_out}, {15'd0, exp_tc});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cpu_sel = 0; cpu_wr = 0; cpu_rd = 0; cpu_addr = '0; cpu_wdata = '0;
        xfer_stb = 0; xfer_ch = '0; eop_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state: every byte reads zero, outputs idle
        #4;
        check(xfer_addr == 16'h0, 1, xfer_addr, 16'h0);
        check(tc_out == 1'b0, 1, {15'd0, tc_out}, 16'h0);
        for (int i = 0; i < 8; i++) begin
            rd_chk(4'(i), 8'h00, 1);
            rd_chk(4'(i), 8'h00, 1);
        end

        // Table walk
        for (int v = 0; v < NV; v++) begin
            case (VEC[v].op)
                2'd0: drive(1, 1, 0, VEC[v].addr, VEC[v].data, 0, 2'd0, 0);
                2'd1: rd_chk(VEC[v].addr, VEC[v].exp[7:0], int'(VEC[v].req));
                default: xfer_chk(VEC[v].data[1:0], VEC[v].data[2], VEC[v].exp,
                                  VEC[v].tc, int'(VEC[v].req));
            endcase
        end

        // R11 collision: ch3 count is 0, a strobe alone would end the run
        drive(1, 1, 0, 4'hC, 8'h00, 0, 2'd0, 0);
        drive(1, 1, 0, 4'h6, 8'h77, 1, 2'd3, 0);
        #4;
        check(tc_out == 1'b0, 11, {15'd0, tc_out}, 16'h0);
        drive(1, 1, 0, 4'h6, 8'h00, 0, 2'd0, 0);
        rd_chk(4'h7, 8'h00, 11);
        rd_chk(4'h7, 8'h00, 11);
        rd_chk(4'h6, 8'h77, 11);
        rd_chk(4'h6, 8'h00, 11);
        // R6 single transfer when the count is already zero
        xfer_chk(2'd3, 0, 16'h0077, 1, 6);
        xfer_chk(2'd3, 0, 16'h0078, 0, 6);

        // R4 non-register read returns zero
        drive(1, 0, 1, 4'hB, 8'h00, 0, 2'd0, 0);
        #4;
        check(cpu_rdata == 8'h00, 4, {8'h00, cpu_rdata}, 16'h0);

        drive(0, 0, 0, 4'h0, 8'h00, 0, 2'd0, 0);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule